// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one page-table entry from memory. A requester presents a virtual address, an access kind (read, write or instruction fetch) and a privilege flag. The walker builds the entry's word address by placing the page-table base value above the virtual page number, which is a concatenation and not a sum. It issues one read on a plain request/response memory port and waits for as long as the memory takes. It then decodes the returned entry and answers with either a physical address or a fault code.

Only one translation is in flight at a time, and the walker holds its ready output low while it works. The physical address keeps the page offset unchanged and replaces the page number with the entry's physical page number. An entry whose valid bit is clear always gives a page fault, whatever its rights bits hold. A valid entry can still refuse the access with a protection fault.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `resp_valid` and `mem_req_valid` are 0.
- R2: In the cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge), `mem_req_valid` is 1 for exactly one cycle and `mem_req_addr` equals {`ptbr`, virtual page number}, where the page number is the upper `VA_W - log2(PAGE_BYTES)` bits of the virtual address.
- R3: `req_ready` is 0 from the cycle after acceptance until the response cycle has passed. Requests offered while it is 0 start no memory read and do not change the result in progress.
- R4: The walker waits any number of cycles for `mem_resp_valid`. `resp_valid` is 1 for exactly one cycle, two clock edges after the edge that sampled `mem_resp_valid`.
- R5: The entry layout is bit 0 valid, bit 1 read-only, bit 2 supervisor-only, and bits [3 +: PPN_W] physical page number. For an allowed access, `resp_fault` is 00 and `resp_paddr` is {physical page number, page offset}.
- R6: If the entry's valid bit is 0, `resp_fault` is 01 (page fault), even when its rights bits would also refuse the access.
- R7: The access kind is coded 00 read, 01 write, 10 fetch. A write to a valid read-only entry gives `resp_fault` 10 (protection fault). A read or fetch of such an entry is allowed.
- R8: With `req_user` = 1, any access to a valid supervisor-only entry gives `resp_fault` 10. With `req_user` = 0 the same access is allowed.
- R9: A `mem_resp_valid` pulse while the walker is idle is ignored. No response appears and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| ptbr | input | PTBR_W | Page-table base value, sampled at acceptance |
| mem_req_valid | output | 1 | One-cycle entry read request |
| mem_req_addr | output | PTBR_W+VPN_W | Word address of the entry |
| mem_resp_valid | input | 1 | Entry data returned |
| mem_resp_data | input | PTE_W | Entry word |
| resp_valid | output | 1 | Translation result valid for one cycle |
| resp_paddr | output | PPN_W+log2(PAGE_BYTES) | Physical address; meaningless when a fault is reported |
| resp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |

## Verification
The bench targets fault priority with an invalid entry whose read-only and supervisor bits are both set, offered as a user write. A design that checked rights first would report 10 there instead of 01. It tests the boundary of the read-only rule by using reads, fetches and writes on the same entry. It also tries the privilege rule in both modes, and a walker that decoded the kind or privilege wrongly would then fault legal accesses or pass illegal ones. Memory latencies of one to several cycles, extra requests offered while busy, and stray memory responses while idle would all expose a walker that sampled data at a fixed delay, re-triggered on its input, or answered with nothing outstanding. The top page number and top offset, together with a changed base value, would expose an address that was added instead of concatenated, or truncated.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // Access kinds.
  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_FETCH = 2'b10;

  // Fault codes.
  localparam logic [1:0] FLT_NONE = 2'b00;
  localparam logic [1:0] FLT_PAGE = 2'b01;
  localparam logic [1:0] FLT_PROT = 2'b10;

  // Entry bit positions.
  localparam int PTE_VALID   = 0;
  localparam int PTE_RDONLY  = 1;
  localparam int PTE_SUPER   = 2;
  localparam int PTE_PPN_LSB = 3;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ    = 3'd1,
    ST_WAIT    = 3'd2,
    ST_CHECK   = 3'd3,
    ST_RESPOND = 3'd4
  } walk_state_t;

endpackage

// File: rtl/ptw_addr_form.sv
module ptw_addr_form #(
  parameter int PTBR_W = 10,
  parameter int VA_W   = 16,
  parameter int OFF_W  = 10,
  localparam int VPN_W = VA_W - OFF_W
) (
  input  logic [PTBR_W-1:0]       base,
  input  logic [VA_W-1:0]         vaddr,
  output logic [PTBR_W+VPN_W-1:0] entry_addr,
  output logic [OFF_W-1:0]        offset
);
  // The base value sits above the page number; no adder is involved.
  assign entry_addr = {base, vaddr[VA_W-1:OFF_W]};
  assign offset     = vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import pt_walker_pkg::*;
#(
  parameter int PTE_W = 16,
  parameter int PPN_W = 5
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       kind,
  input  logic             user,
  output logic [1:0]       fault,
  output logic [PPN_W-1:0] ppn
);
  logic wr_denied;
  logic priv_denied;

  assign ppn         = pte[PTE_PPN_LSB +: PPN_W];
  assign wr_denied   = (kind == KIND_WRITE) && pte[PTE_RDONLY];
  assign priv_denied = user && pte[PTE_SUPER];

  always_comb begin
    if (!pte[PTE_VALID])
      fault = FLT_PAGE;            // rights of an invalid entry are ignored
    else if (wr_denied || priv_denied)
      fault = FLT_PROT;
    else
      fault = FLT_NONE;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W       = 16,
  parameter int PAGE_BYTES = 1024,
  parameter int PPN_W      = 5,
  parameter int PTBR_W     = 10,
  parameter int PTE_W      = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int MAW       = PTBR_W + VPN_W,
  localparam int PA_W      = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic [PTBR_W-1:0] ptbr,
  output logic              mem_req_valid,
  output logic [MAW-1:0]    mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [PTE_W-1:0]  mem_resp_data,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_paddr,
  output logic [1:0]        resp_fault
);

  walk_state_t state;

  logic [MAW-1:0]   addr_c;
  logic [OFF_W-1:0] off_c;
  logic [OFF_W-1:0] off_q;
  logic [1:0]       kind_q;
  logic             user_q;
  logic [PTE_W-1:0] pte_q;
  logic [MAW-1:0]   addr_q;
  logic [1:0]       fault_c;
  logic [PPN_W-1:0] ppn_c;
  logic [PA_W-1:0]  paddr_q;
  logic [1:0]       fault_q;

  ptw_addr_form #(
    .PTBR_W (PTBR_W),
    .VA_W   (VA_W),
    .OFF_W  (OFF_W)
  ) u_addr (
    .base       (ptbr),
    .vaddr      (req_vaddr),
    .entry_addr (addr_c),
    .offset     (off_c)
  );

  ptw_pte_check #(
    .PTE_W (PTE_W),
    .PPN_W (PPN_W)
  ) u_check (
    .pte   (pte_q),
    .kind  (kind_q),
    .user  (user_q),
    .fault (fault_c),
    .ppn   (ppn_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      off_q   <= '0;
      kind_q  <= KIND_READ;
      user_q  <= 1'b0;
      pte_q   <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q <= addr_c;
            off_q  <= off_c;
            kind_q <= req_kind;
            user_q <= req_user;
            state  <= ST_READ;
          end
        end
        ST_READ: state <= ST_WAIT;
        ST_WAIT: begin
          if (mem_resp_valid) begin
            pte_q <= mem_resp_data;
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          paddr_q <= {ppn_c, off_q};
          fault_q <= fault_c;
          state   <= ST_RESPOND;
        end
        ST_RESPOND: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_READ);
  assign mem_req_addr  = addr_q;
  assign resp_valid    = (state == ST_RESPOND);
  assign resp_paddr    = paddr_q;
  assign resp_fault    = fault_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PTE_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_resp_valid,
  input logic [PTE_W-1:0] mem_resp_data,
  input logic             resp_valid,
  input logic [1:0]       resp_fault,
  input logic [2:0]       state
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (req_ready && !resp_valid && !mem_req_valid));

  a_r2_read_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_req_valid);

  a_r2_single_read: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  a_r3_busy_on_resp: assert property (@(posedge clk) disable iff (rst)
    (resp_valid || mem_req_valid) |-> !req_ready);

  a_r4_resp_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  a_r5_code_legal: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_fault != 2'b11));

  // R6: invalid entry taken in the wait state ends as a page fault.
  a_r6_invalid_page_fault: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd2 && mem_resp_valid && !mem_resp_data[0])
      |=> ##1 (resp_valid && resp_fault == 2'b01));

  a_r9_idle_resp_ignored: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !req_valid && mem_resp_valid) |=> req_ready);

endmodule

bind pt_walker pt_walker_chk #(.PTE_W(PTE_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .mem_req_valid  (mem_req_valid),
  .mem_resp_valid (mem_resp_valid),
  .mem_resp_data  (mem_resp_data),
  .resp_valid     (resp_valid),
  .resp_fault     (resp_fault),
  .state          (state)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int VA_W = 16, PAGE_BYTES = 1024, PPN_W = 5, PTBR_W = 10, PTE_W = 16;
  localparam int OFF_W = 10, VPN_W = 6, MAW = 16, PA_W = 15;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_user = 0, mem_resp_valid = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_kind = 2'b00;
  logic [PTBR_W-1:0] ptbr = '0;
  logic [PTE_W-1:0] mem_resp_data = '0;
  logic req_ready, mem_req_valid, resp_valid;
  logic [MAW-1:0] mem_req_addr;
  logic [PA_W-1:0] resp_paddr;
  logic [1:0] resp_fault;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [PTE_W-1:0] pte_mem [int];

  always #4 clk = ~clk;  // 125 MHz

  pt_walker #(.VA_W(VA_W), .PAGE_BYTES(PAGE_BYTES), .PPN_W(PPN_W),
              .PTBR_W(PTBR_W), .PTE_W(PTE_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_user(req_user), .ptbr(ptbr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Reference: expected fault from kind, privilege and entry.
  function automatic logic [1:0] ref_fault(logic [PTE_W-1:0] p, logic [1:0] k, logic u);
    if (p[0] == 1'b0) return 2'b01;
    if ((k == 2'b01 && p[1]) || (u && p[2])) return 2'b10;
    return 2'b00;
  endfunction

  task automatic xlate(logic [PTBR_W-1:0] base, logic [VA_W-1:0] va, logic [1:0] kind,
                       logic user, int lat, bit spam, string tag);
    int ea;
    logic [PTE_W-1:0] p;
    logic [1:0] ef;
    ea = int'({base, va[VA_W-1:OFF_W]});
    p  = pte_mem.exists(ea) ? pte_mem[ea] : '0;
    ef = ref_fault(p, kind, user);
    @(negedge clk);
    check({tag, " R3 ready idle"}, 32'(req_ready), 1);
    req_valid = 1; req_vaddr = va; req_kind = kind; req_user = user; ptbr = base;
    @(negedge clk);
    check({tag, " R2 read issued"}, 32'(mem_req_valid), 1);
    check({tag, " R2 entry addr"}, 32'(mem_req_addr), 32'(ea));
    check({tag, " R3 busy"}, 32'(req_ready), 0);
    if (spam) begin
      req_vaddr = ~va; req_kind = 2'b01; req_user = 1; ptbr = ~base;
    end else req_valid = 0;
    for (int i = 1; i < lat; i++) begin
      @(negedge clk);
      check({tag, " R2 one read"}, 32'(mem_req_valid), 0);
      check({tag, " R4 no early resp"}, 32'(resp_valid), 0);
    end
    @(negedge clk);
    mem_resp_valid = 1; mem_resp_data = p;
    @(negedge clk);
    mem_resp_valid = 0; mem_resp_data = '0;
    check({tag, " R4 not yet"}, 32'(resp_valid), 0);
    @(negedge clk);
    check({tag, " R4 resp"}, 32'(resp_valid), 1);
    check({tag, " R5-8 fault"}, 32'(resp_fault), 32'(ef));
    if (ef == 2'b00)
      check({tag, " R5 paddr"}, 32'(resp_paddr), 32'({p[3 +: PPN_W], va[OFF_W-1:0]}));
    req_valid = 0;
    @(negedge clk);
    check({tag, " R4 pulse"}, 32'(resp_valid), 0);
    check({tag, " R3 ready again"}, 32'(req_ready), 1);
    check({tag, " R3 no extra read"}, 32'(mem_req_valid), 0);
  endtask

  initial begin
    // entry = {ppn, super, rdonly, valid}
    pte_mem[int'({10'h005, 6'd1})]  = 16'((7  << 3) | 1);        // rw
    pte_mem[int'({10'h005, 6'd2})]  = 16'((12 << 3) | 3);        // read-only
    pte_mem[int'({10'h005, 6'd3})]  = 16'((20 << 3) | 5);        // supervisor
    pte_mem[int'({10'h005, 6'd4})]  = 16'((9  << 3) | 6);        // invalid, rights set
    pte_mem[int'({10'h3A1, 6'd63})] = 16'((31 << 3) | 1);        // top page

    repeat (2) @(negedge clk);
    check("R1 ready in reset", 32'(req_ready), 1);
    check("R1 no resp in reset", 32'(resp_valid), 0);
    check("R1 no read in reset", 32'(mem_req_valid), 0);
    rst = 0;
    @(negedge clk);
    check("R1 ready after reset", 32'(req_ready), 1);

    xlate(10'h005, {6'd1, 10'h123}, 2'b00, 0, 1, 0, "R5 rw read");
    xlate(10'h005, {6'd1, 10'h3FF}, 2'b01, 1, 3, 0, "R5 rw user write");
    xlate(10'h005, {6'd9, 10'h010}, 2'b00, 0, 2, 0, "R6 empty entry");
    xlate(10'h005, {6'd4, 10'h001}, 2'b01, 1, 1, 0, "R6 invalid priority");
    xlate(10'h005, {6'd2, 10'h044}, 2'b01, 0, 2, 0, "R7 write ro");
    xlate(10'h005, {6'd2, 10'h045}, 2'b00, 1, 1, 0, "R7 read ro");
    xlate(10'h005, {6'd2, 10'h046}, 2'b10, 0, 4, 0, "R7 fetch ro");
    xlate(10'h005, {6'd3, 10'h200}, 2'b00, 1, 1, 0, "R8 user super");
    xlate(10'h005, {6'd3, 10'h201}, 2'b10, 1, 2, 0, "R8 user fetch super");
    xlate(10'h005, {6'd3, 10'h202}, 2'b01, 0, 1, 0, "R8 sup write super");
    xlate(10'h3A1, {6'd63, 10'h3FF}, 2'b10, 0, 5, 1, "R3 busy spam top");
    xlate(10'h005, {6'd1, 10'h000}, 2'b01, 0, 6, 1, "R3 busy spam rw");

    // R9: stray memory response while idle.
    @(negedge clk);
    mem_resp_valid = 1; mem_resp_data = 16'hFFFF;
    @(negedge clk);
    mem_resp_valid = 0;
    check("R9 still ready", 32'(req_ready), 1);
    check("R9 no resp", 32'(resp_valid), 0);
    @(negedge clk);
    check("R9 no resp later", 32'(resp_valid), 0);
    check("R9 no read", 32'(mem_req_valid), 0);
    xlate(10'h005, {6'd1, 10'h055}, 2'b00, 0, 1, 0, "R9 after stray");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule